// File: doc/BRIEF.md
# Serial bootstrap memory loader

This block lets a board start with no program in memory. A strap input is sampled while reset is applied. If the strap is high, the processor is kept off the bus from reset onward. Bytes then arrive on an asynchronous serial line, and each one is written into memory at the next address, counting up from zero. Once the final byte of the fixed-length image has been stored, the hold is dropped. The processor then starts fetching from address zero, where the first loaded byte sits. If the strap is low at reset, the hold is never raised, the serial line is ignored and the processor boots from whatever memory already holds.

The receiver expects one start bit, eight data bits sent least significant first, no parity and one stop bit, with no flow control. The bit period is a fixed number of system clocks: 192 by default, which gives 115200 baud from a 22.1184 MHz clock. Any line activity after the release, and any strap change after reset, leaves the block untouched until the next reset.

Top module: `serial_boot_loader`

## Requirements
- R1: When `boot_strap` is 0 during reset, `cpu_hold` is 0 from the first cycle after reset, and no `mem_we` strobe is ever produced, whatever arrives on `rx`.
- R2: When `boot_strap` is 1 during reset, `cpu_hold` is 1 (processor held off the bus) from reset until the last image byte has been written.
- R3: In load mode, each received frame produces one write. The k-th frame received after reset is written at address k, starting at k = 0. Its data is the eight data bits taken least significant first. A frame is line idle high, then a start bit at 0, then 8 data bits, then a stop bit at 1, with each bit lasting CLKS_PER_BIT clocks.
- R4: A low pulse on `rx` that is shorter than half a bit period is treated as noise and produces no write.
- R5: Every `mem_we` strobe is high for exactly one clock cycle, and `mem_addr` never exceeds LOAD_BYTES-1 while the strobe is high.
- R6: Exactly LOAD_BYTES writes (default 255, addresses 0x00 to 0xFE) are made. `cpu_hold` falls one cycle after the strobe for address LOAD_BYTES-1.
- R7: After release, further serial frames cause no write and `cpu_hold` stays 0 until the next reset.
- R8: `boot_strap` is only sampled during reset. Changing it afterwards changes neither `cpu_hold` nor the loading behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the bit-rate reference |
| rst_n | input | 1 | Synchronous reset, active low; `boot_strap` is sampled while it is low |
| boot_strap | input | 1 | Mode strap: 1 selects serial load, 0 selects normal boot |
| rx | input | 1 | Asynchronous serial receive line, idle high |
| mem_addr | output | ADDR_W | Write address for the byte being stored |
| mem_wdata | output | 8 | Byte being stored |
| mem_we | output | 1 | One-cycle memory write strobe, active high |
| cpu_hold | output | 1 | 1 keeps the processor tri-stated; 0 lets it run from address 0 |

## Verification
A byte's write strobe is not produced at a fixed offset from the moment the bench starts a frame. It comes two synchronizer stages plus one register after the middle of the stop bit. For that reason the bench logs every strobe, with its address, data and cycle number, from a monitor that samples on the falling edge, and compares the log with the bytes it sent. The release is checked against that log: `cpu_hold` must read low exactly one sampled cycle after the last strobe. Checks that something is ignored (noise pulses, traffic after release, traffic in normal-boot mode) wait at least one full frame time before reading the strobe count and `cpu_hold`.

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int CLKS_PER_BIT = 192,
  parameter int LOAD_BYTES   = 255,
  parameter int ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  input  logic              rx,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              cpu_hold
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LOAD_BYTES - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_t;

  logic              loading, finish, byte_ok;
  logic [1:0]        rx_sync;
  rx_t               rx_st;
  logic [CW-1:0]     tick;
  logic [2:0]        bit_n;
  logic [7:0]        shreg;
  logic [ADDR_W-1:0] wr_idx;
  logic              rx_s;

  assign rx_s     = rx_sync[1];
  assign cpu_hold = loading;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !loading) begin
      rx_st   <= RX_IDLE;
      tick    <= '0;
      bit_n   <= '0;
      shreg   <= '0;
      byte_ok <= 1'b0;
    end else begin
      byte_ok <= 1'b0;
      case (rx_st)
        RX_IDLE: if (!rx_s) begin
          rx_st <= RX_START;
          tick  <= '0;
        end
        RX_START: begin
          if (rx_s) rx_st <= RX_IDLE;
          else if (tick == HALF_M1) begin
            rx_st <= RX_DATA;
            tick  <= '0;
            bit_n <= '0;
          end else tick <= tick + 1'b1;
        end
        RX_DATA: begin
          if (tick == FULL_M1) begin
            tick  <= '0;
            shreg <= {rx_s, shreg[7:1]};
            bit_n <= bit_n + 1'b1;
            if (bit_n == 3'd7) rx_st <= RX_STOP;
          end else tick <= tick + 1'b1;
        end
        default: begin
          if (tick == FULL_M1) begin
            tick    <= '0;
            rx_st   <= RX_IDLE;
            byte_ok <= 1'b1;
          end else tick <= tick + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading   <= boot_strap;
      finish    <= 1'b0;
      wr_idx    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (finish) begin
        loading <= 1'b0;
        finish  <= 1'b0;
      end else if (loading && byte_ok) begin
        mem_we    <= 1'b1;
        mem_addr  <= wr_idx;
        mem_wdata <= shreg;
        wr_idx    <= wr_idx + 1'b1;
        finish    <= (wr_idx == LAST);
      end
    end
  end

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5
  we_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= LAST));

  // R6
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> ($past(mem_we) && $past(mem_addr) == LAST));

  // R7
  no_write_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |-> !mem_we);

  // R8
  hold_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cpu_hold));
endmodule

// File: tb/serial_boot_loader_bench.sv
module serial_boot_loader_bench;
  localparam int CLKS = 16;
  localparam int NB   = 255;

  logic clk = 1'b0, rst_n = 1'b0, boot_strap = 1'b1, rx = 1'b1;
  logic [7:0] mem_addr, mem_wdata;
  logic mem_we, cpu_hold;

  always #2.5 clk = ~clk;

  serial_boot_loader #(.CLKS_PER_BIT(CLKS), .LOAD_BYTES(NB), .ADDR_W(8)) u_serial_boot_loader (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .rx(rx),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .cpu_hold(cpu_hold));

  int checks = 0, fails = 0, cyc = 0, n_wr = 0, doubles = 0;
  int last_we_cyc = -1, fall_cyc = -1;
  logic prev_we = 1'b0, prev_hold = 1'b0, done = 1'b0;
  logic [7:0] wa [0:599];
  logic [7:0] wd [0:599];
  logic [7:0] exp_b [0:NB-1];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_we) begin
        if (n_wr < 600) begin wa[n_wr] = mem_addr; wd[n_wr] = mem_wdata; end
        n_wr = n_wr + 1;
        last_we_cyc = cyc;
        if (prev_we) doubles = doubles + 1;
      end
      if (prev_hold && !cpu_hold) fall_cyc = cyc;
    end
    prev_we   = mem_we;
    prev_hold = cpu_hold;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx = 1'b0; wait_clks(CLKS);
    for (int i = 0; i < 8; i++) begin rx = b[i]; wait_clks(CLKS); end
    rx = 1'b1; wait_clks(CLKS);
  endtask

  task automatic do_reset(input logic strap);
    boot_strap = strap;
    rst_n = 1'b0;
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(1);
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: pick = 8'h00; 1: pick = 8'hFF; 2: pick = 8'h55;
      3: pick = 8'hAA; 4: pick = 8'h01; 5: pick = 8'h80;
      default: pick = 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    wait_clks(2);
    do_reset(1'b1);
    chk(cpu_hold == 1'b1, "R2 hold after reset", cpu_hold, 1);
    chk(mem_we == 1'b0, "R2 no strobe after reset", mem_we, 0);
    boot_strap = 1'b0;
    wait_clks(3);
    chk(cpu_hold == 1'b1, "R8 strap drop during load", cpu_hold, 1);

    rx = 1'b0; wait_clks(3); rx = 1'b1; wait_clks(3 * CLKS);
    chk(n_wr == 0, "R4 3-clock glitch", n_wr, 0);
    rx = 1'b0; wait_clks(CLKS / 2 - 1); rx = 1'b1; wait_clks(12 * CLKS);
    chk(n_wr == 0, "R4 near-half glitch", n_wr, 0);

    for (int i = 0; i < NB; i++) exp_b[i] = pick(i);
    for (int i = 0; i < NB; i++) begin
      if (i == NB - 1) chk(cpu_hold == 1'b1, "R2 hold before last byte", cpu_hold, 1);
      send_byte(exp_b[i]);
      wait_clks($urandom_range(0, 20));
    end
    wait_clks(4);
    chk(n_wr == NB, "R6 write count", n_wr, NB);
    for (int i = 0; i < NB; i++) begin
      chk(wa[i] == 8'(i), "R3 address", wa[i], i);
      chk(wd[i] == exp_b[i], "R3 data", wd[i], exp_b[i]);
    end
    chk(cpu_hold == 1'b0, "R6 released", cpu_hold, 0);
    chk(fall_cyc == last_we_cyc + 1, "R6 release cycle", fall_cyc, last_we_cyc + 1);
    chk(doubles == 0, "R5 single-cycle strobe", doubles, 0);

    boot_strap = 1'b1;
    send_byte(8'h3C); send_byte(8'hC3); send_byte(8'h00);
    wait_clks(2 * CLKS);
    chk(n_wr == NB, "R7 no write after release", n_wr, NB);
    chk(cpu_hold == 1'b0, "R7 hold stays low", cpu_hold, 0);
    chk(cpu_hold == 1'b0, "R8 strap raise after release", cpu_hold, 0);

    do_reset(1'b0);
    base = n_wr;
    chk(cpu_hold == 1'b0, "R1 no hold in normal boot", cpu_hold, 0);
    send_byte(8'h12); send_byte(8'hE7);
    wait_clks(2 * CLKS);
    chk(n_wr == base, "R1 no writes in normal boot", n_wr, base);
    boot_strap = 1'b1;
    wait_clks(4);
    chk(cpu_hold == 1'b0, "R8 strap raise in normal boot", cpu_hold, 0);

    do_reset(1'b1);
    base = n_wr;
    chk(cpu_hold == 1'b1, "R2 hold after second reset", cpu_hold, 1);
    send_byte(8'h9D);
    wait_clks(4);
    chk(n_wr == base + 1, "R3 restart count", n_wr, base + 1);
    chk(wa[base] == 8'h00, "R3 restart address", wa[base], 0);
    chk(wd[base] == 8'h9D, "R3 restart data", wd[base], 8'h9D);
    chk(doubles == 0, "R5 single-cycle strobe end", doubles, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule